// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the SCL clock of an I2C master. Two programmable counts set the length of the low phase and of the high phase. Both counts are measured in ticks of a prescaled count clock, and each tick lasts a programmable number of input clocks. SCL is driven open-drain: `scl_oe` high pulls the line low, and `scl_oe` low releases it. The block also watches the line through a synchronizer, so a slow rise or a slave that stretches the clock does not shorten the high phase.

The low phase is timed from the first cycle in which the block pulls SCL low. The high phase is timed only once the synchronized SCL input reads high. Each count is built from an 8-bit base value plus a separate ninth bit. When the generator is enabled it starts with a high phase timed by the high count, which gives the START hold time between the byte engine dropping SDA and the first SCL fall. One-cycle pulses mark each SCL fall and each timed rise, so a byte engine can sequence data around them. Bus protocol sequencing is not part of this block.

Top module: `scl_period_gen`

## Requirements
- R1: The block drives `scl_oe` high for exactly Lc × Dc consecutive cycles per low phase. Lc is the effective low count and Dc the effective tick divider.
- R2: The high phase starts only after the synchronized SCL input reads high. It lasts exactly Hc × Dc cycles, from the cycle `scl_rise` is high up to the cycle before `scl_fall` is high, however long the line was held low after release.
- R3: The effective counts are Lc = 256·`lo_ext` + `lo_cnt` and Hc = 256·`hi_ext` + `hi_cnt`.
- R4: An effective count of 0 acts as 1.
- R5: Each tick lasts `tick_div` input clocks, and a `tick_div` of 0 acts as 1.
- R6: One cycle after `en` falls, `scl_oe` is low. While `en` is low no pulse is emitted. Timing restarts from zero when `en` rises again.
- R7: After `en` rises, the first event is a rise pulse, followed by a full high phase (the START hold) before the first fall, with SCL released throughout.
- R8: `scl_fall` is a one-cycle pulse in the first cycle that `scl_oe` is high. `scl_rise` is a one-cycle pulse in the first cycle of the high phase. The two are never high together.
- R9: `scl_level` equals `scl_in` delayed by SYNC_STAGES clock cycles (default 2).

Count arithmetic (R1–R5): with `lo_cnt`=5 and a divider of 1 the low phase lasts 5 cycles. With `hi_cnt`=3 and a divider of 3 the high phase lasts 9 cycles. With `lo_cnt`=4 and `lo_ext`=1 the low phase lasts 260 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generator run enable |
| lo_cnt | input | 8 | Low-phase count, base bits |
| lo_ext | input | 1 | Low-phase count, ninth bit |
| hi_cnt | input | 8 | High-phase count, base bits |
| hi_ext | input | 1 | High-phase count, ninth bit |
| tick_div | input | 8 | Input clocks per count tick |
| scl_in | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_level | output | 1 | Synchronized SCL level |
| scl_fall | output | 1 | One-cycle pulse at SCL fall |
| scl_rise | output | 1 | One-cycle pulse at timed SCL rise |

## Verification
The bench holds the line low for a long stretch after release. A design that counts the high phase from release would either cut the high phase short or emit its rise pulse while the line is still held. Zero counts and a zero divider are driven to catch a counter that underflows and wraps to a 256- or 512-tick phase. The ninth bits are set on both counts to catch a design that wires an extension bit to the wrong phase or drops it. Disabling in mid-phase and re-enabling checks that no pulse leaks out and that the first high phase after re-enable is full length, not a leftover partial count.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,
      PH_WAIT = 2'd1,
      PH_HIGH = 2'd2,
      PH_LOW  = 2'd3
   } scl_phase_e;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("scl_in_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign d_out = d_in;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '1;
         else        sh_q <= {sh_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_in};
      end
      assign d_out = sh_q[STAGES-1];
   end
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
   parameter int PS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic [PS_W-1:0] div,
   output logic            tick
);
   if (PS_W < 1) begin : g_bad_w
      $error("scl_tick_gen: PS_W must be at least 1");
   end

   logic [PS_W-1:0] div_eff;
   logic [PS_W-1:0] pcnt_q;

   assign div_eff = (div == '0) ? PS_W'(1) : div;
   assign tick    = (pcnt_q == div_eff - PS_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pcnt_q <= '0;
      else if (clr || tick)  pcnt_q <= '0;
      else                   pcnt_q <= pcnt_q + PS_W'(1);
   end

   AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tick) |-> (pcnt_q == '0)); // R5
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
   parameter int PH_W = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            tick,
   input  logic [PH_W-1:0] limit,
   output logic            done
);
   if (PH_W < 2) begin : g_bad_w
      $error("scl_phase_ctr: PH_W must be at least 2");
   end

   logic [PH_W-1:0] lim_eff;
   logic [PH_W-1:0] cnt_q;

   assign lim_eff = (limit == '0) ? PH_W'(1) : limit;
   assign done    = tick && (cnt_q == lim_eff - PH_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + PH_W'(1);
   end

   AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (cnt_q == '0)); // R1
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
   import scl_gen_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter bit HAS_EXT     = 1'b1,
   parameter int PS_W        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] lo_cnt,
   input  logic             lo_ext,
   input  logic [CNT_W-1:0] hi_cnt,
   input  logic             hi_ext,
   input  logic [PS_W-1:0]  tick_div,
   input  logic             scl_in,
   output logic             scl_oe,
   output logic             scl_level,
   output logic             scl_fall,
   output logic             scl_rise
);
   localparam int PH_W = HAS_EXT ? CNT_W + 1 : CNT_W;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("scl_period_gen: CNT_W must be at least 2");
   end

   logic [PH_W-1:0] lo_full, hi_full, limit;

   if (HAS_EXT) begin : g_ext
      assign lo_full = {lo_ext, lo_cnt};
      assign hi_full = {hi_ext, hi_cnt};
   end else begin : g_noext
      logic unused_ext;
      assign unused_ext = lo_ext ^ hi_ext;
      assign lo_full    = lo_cnt;
      assign hi_full    = hi_cnt;
   end

   logic scl_sync;
   scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (scl_in),
      .d_out (scl_sync)
   );

   scl_phase_e st_q, st_n;
   logic       clr, tick, done;

   assign limit = (st_q == PH_HIGH) ? hi_full : lo_full;

   always_comb begin
      st_n = st_q;
      if (!en) st_n = PH_OFF;
      else begin
         unique case (st_q)
            PH_OFF:  st_n = PH_WAIT;
            PH_WAIT: if (scl_sync) st_n = PH_HIGH;
            PH_HIGH: if (done)     st_n = PH_LOW;
            PH_LOW:  if (done)     st_n = PH_WAIT;
            default: st_n = PH_OFF;
         endcase
      end
   end

   assign clr = (st_n != st_q) || (st_q == PH_OFF) || (st_q == PH_WAIT);

   scl_tick_gen #(.PS_W(PS_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .div   (tick_div),
      .tick  (tick)
   );

   scl_phase_ctr #(.PH_W(PH_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .tick  (tick),
      .limit (limit),
      .done  (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PH_OFF;
         scl_oe   <= 1'b0;
         scl_fall <= 1'b0;
         scl_rise <= 1'b0;
      end else begin
         st_q     <= st_n;
         scl_oe   <= (st_n == PH_LOW);
         scl_fall <= (st_n == PH_LOW)  && (st_q != PH_LOW);
         scl_rise <= (st_n == PH_HIGH) && (st_q != PH_HIGH);
      end
   end

   assign scl_level = scl_sync;

   AST_FALL_AT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall |-> (scl_oe && !$past(scl_oe))); // R8
   AST_PULSES_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_fall && scl_rise)); // R8
   AST_RISE_SEEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise |-> $past(scl_sync)); // R2
   AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!scl_oe && !scl_fall && !scl_rise)); // R6
endmodule

// File: tb/scl_period_gen_bench.sv
module scl_period_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] lo_cnt = 8'd1, hi_cnt = 8'd1, tick_div = 8'd1;
   logic       lo_ext = 1'b0, hi_ext = 1'b0;
   logic       hold = 1'b0;
   logic       scl_in, scl_oe, scl_level, scl_fall, scl_rise;

   int n_tests = 0, n_fail = 0;
   int fall_cnt = 0, rise_cnt = 0;
   int hi_run = 0, hi_last = 0, lo_run = 0, lo_last = 0;
   logic in_high = 1'b0, prev_oe = 1'b0;

   always #5 clk = ~clk;

   assign scl_in = !(scl_oe || hold);

   scl_period_gen u_scl_period_gen (
      .clk(clk), .rst_n(rst_n), .en(en),
      .lo_cnt(lo_cnt), .lo_ext(lo_ext), .hi_cnt(hi_cnt), .hi_ext(hi_ext),
      .tick_div(tick_div), .scl_in(scl_in), .scl_oe(scl_oe),
      .scl_level(scl_level), .scl_fall(scl_fall), .scl_rise(scl_rise)
   );

   always @(negedge clk) begin
      if (scl_fall) begin
         fall_cnt++;
         if (in_high) hi_last = hi_run;
         in_high = 1'b0;
      end else if (in_high) hi_run++;
      if (scl_rise) begin
         rise_cnt++;
         in_high = 1'b1;
         hi_run  = 1;
      end
      if (!en) in_high = 1'b0;
      if (scl_oe) lo_run++;
      else if (prev_oe) begin
         lo_last = lo_run;
         lo_run  = 0;
      end
      prev_oe = scl_oe;
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic wait_falls(input int n);
      int target = fall_cnt + n;
      while (fall_cnt < target) step();
   endtask

   task automatic wait_rises(input int n);
      int target = rise_cnt + n;
      while (rise_cnt < target) step();
   endtask

   task automatic configure(input int lo, input int le, input int hi, input int he, input int dv);
      @(negedge clk);
      en = 1'b0;
      repeat (3) @(negedge clk);
      lo_cnt = 8'(lo); lo_ext = le[0]; hi_cnt = 8'(hi); hi_ext = he[0]; tick_div = 8'(dv);
      en = 1'b1;
   endtask

   task automatic t_reset();
      step();
      check("R6 reset oe", int'(scl_oe), 0);
      check("R8 reset pulses", int'(scl_fall) + int'(scl_rise), 0);
   endtask

   task automatic t_timing(input string tag, input int lo, input int le, input int hi,
                           input int he, input int dv, input int exp_lo, input int exp_hi);
      configure(lo, le, hi, he, dv);
      wait_falls(2);
      check({tag, " high length"}, hi_last, exp_hi);
      wait_rises(1);
      check({tag, " low length"}, lo_last, exp_lo);
   endtask

   task automatic t_start_hold();
      int f0, r0, lo0;
      @(negedge clk);
      en = 1'b0;
      repeat (3) @(negedge clk);
      lo_cnt = 8'd3; hi_cnt = 8'd7; lo_ext = 1'b0; hi_ext = 1'b0; tick_div = 8'd2;
      en = 1'b1;
      f0 = fall_cnt; r0 = rise_cnt; lo0 = lo_run;
      wait_rises(1);
      check("R7 no fall before first rise", fall_cnt - f0, 0);
      check("R7 line released before hold", lo_run - lo0, 0);
      wait_falls(1);
      check("R7 start hold length", hi_last, 14);
      check("R7 one rise before first fall", rise_cnt - r0, 1);
   endtask

   task automatic t_pulse_width();
      int w = 0;
      configure(4, 0, 4, 0, 1);
      wait_falls(1);
      check("R8 fall with drive", int'(scl_oe), 1);
      step();
      check("R8 fall one cycle", int'(scl_fall), 0);
      wait_rises(1);
      step();
      check("R8 rise one cycle", int'(scl_rise), 0);
      w = 0;
   endtask

   task automatic t_stretch();
      int r0;
      configure(4, 0, 6, 0, 1);
      wait_falls(2);
      hold = 1'b1;
      r0 = rise_cnt;
      repeat (30) step();
      check("R2 no rise while held low", rise_cnt - r0, 0);
      hold = 1'b0;
      wait_falls(1);
      check("R2 high length after stretch", hi_last, 6);
   endtask

   task automatic t_disable();
      int f0, r0;
      configure(20, 0, 9, 0, 1);
      wait_falls(2);
      repeat (3) step();
      en = 1'b0;
      step();
      check("R6 oe low after disable", int'(scl_oe), 0);
      f0 = fall_cnt; r0 = rise_cnt;
      repeat (20) step();
      check("R6 no pulses while off", (fall_cnt - f0) + (rise_cnt - r0), 0);
      en = 1'b1;
      wait_falls(1);
      check("R6 fresh high after re-enable", hi_last, 9);
   endtask

   task automatic t_sync();
      @(negedge clk);
      en = 1'b0;
      repeat (3) @(negedge clk);
      hold = 1'b1;
      step();
      check("R9 level after one edge", int'(scl_level), 1);
      step();
      check("R9 level after two edges", int'(scl_level), 0);
      hold = 1'b0;
      step();
      step();
      check("R9 level back high", int'(scl_level), 1);
   endtask

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_timing("R1 basic", 5, 0, 4, 0, 1, 5, 4);
      t_timing("R5 divider", 2, 0, 3, 0, 3, 6, 9);
      t_timing("R4 zero counts", 0, 0, 0, 0, 1, 1, 1);
      t_timing("R5 zero divider", 3, 0, 2, 0, 0, 3, 2);
      t_timing("R3 ninth bits", 4, 1, 2, 1, 1, 260, 258);
      t_timing("R3 low ext only", 1, 1, 5, 0, 1, 257, 5);
      t_start_hold();
      t_pulse_width();
      t_stretch();
      t_disable();
      t_sync();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule